// File: doc/BRIEF.md
# Batch-Based Request Scheduler for One DRAM Bank

This block picks which queued memory request goes next to a single DRAM bank. Several hardware threads share a small request queue. Each slot holds a thread number, a row address, a waiting-time counter and an occupancy flag. Requests enter through a one-request-per-cycle port and go into the lowest free slot. A request offered while the queue is full is dropped.

Scheduling runs in batches. When the bank is ready and no batch request is left in the queue, the block opens a new batch. It tags, for every thread, at most a fixed number of that thread's oldest waiting requests. That cycle issues nothing.

While a batch is in progress, each ready cycle grants one request. The order of tests is:
1. Batch membership.
2. A hit on the currently open row.
3. Thread rank. A thread with fewer tagged requests ranks higher, and the lower thread number wins a tie.
4. Age.

The grant appears one cycle later as a single-cycle pulse with the slot index and row. The granted slot is freed, and its row becomes the open row.

Top module: `batch_sched`

## Requirements
- R1: When a batch opens, each thread gets at most CAP (default 2) of its waiting requests tagged, and these are its oldest ones. An untagged request of that thread stays out of the batch even if it hits the open row.
- R2: A tagged request always wins over an untagged one, even when the untagged one hits the open row.
- R3: Between requests with the same batch status, one whose row equals the open row wins over one whose row does not.
- R4: If batch status and row-hit status are equal, the request whose thread has fewer tagged requests in the queue wins. With equal counts, the lower thread number wins.
- R5: If batch status, hit status and thread rank all tie, the request that has waited longer wins. A slot's waiting time restarts at zero when it is filled. Slots filled in successive cycles are served oldest first.
- R6: A batch opens only on a cycle with bank_ready high, at least one occupied slot and no tagged request left. That cycle produces no grant. A request arriving during a batch waits for the next batch.
- R7: After each clock edge with bank_ready high and a batch in progress, grant_valid is high for exactly one cycle. It carries grant_idx and grant_row of the winner, the slot is freed, and the open row takes the granted row. With nothing to serve, grant_valid is low.
- R8: A request fills the lowest-numbered free slot. When all NQ (default 8) slots are occupied, a new request is ignored, so only NQ grants follow.
- R9: After reset, grant_valid is low, the queue is empty and the open row is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New request offered this cycle |
| req_thread | input | TW (2) | Thread number of the new request |
| req_row | input | RW (8) | Row address of the new request |
| bank_ready | input | 1 | Bank can take a request this cycle |
| grant_valid | output | 1 | One-cycle pulse marking a grant |
| grant_idx | output | IW (3) | Queue slot of the granted request |
| grant_row | output | RW (8) | Row of the granted request |

## Verification
Most internal faults in this block show up at the ports on the very next grant, as a wrong slot index. The affected state includes a mis-set batch tag, a stale open row, a wrong per-thread count or a miscounted age. The stimulus is laid out so that each priority rule alone decides at least one grant. A faulty rule therefore changes an index within one or two cycles. A batch opened too early or too late shifts the one-cycle bubble. That moves every later grant by one cycle, which the cycle-exact vector table catches. Queue-full handling only shows up as the total count of grants after draining.

// File: rtl/batch_sched.sv
module batch_sched #(
  parameter int NQ  = 8,
  parameter int NT  = 4,
  parameter int RW  = 8,
  parameter int AW  = 6,
  parameter int CAP = 2,
  localparam int IW = $clog2(NQ),
  localparam int TW = $clog2(NT),
  localparam int CW = $clog2(NQ + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [TW-1:0] req_thread,
  input  logic [RW-1:0] req_row,
  input  logic          bank_ready,
  output logic          grant_valid,
  output logic [IW-1:0] grant_idx,
  output logic [RW-1:0] grant_row
);

  logic [NQ-1:0] valid, mark, mark_new, hit;
  logic [TW-1:0] thr [NQ];
  logic [RW-1:0] row [NQ];
  logic [AW-1:0] age [NQ];
  logic [RW-1:0] open_row;
  logic [CW-1:0] cnt [NT];
  logic [IW-1:0] win, slot;
  logic          have_batch, form, fire, full;

  assign have_batch = |(valid & mark);
  assign form       = bank_ready && !have_batch && (|valid);
  assign fire       = bank_ready && have_batch;
  assign full       = &valid;

  always_comb
    for (int i = 0; i < NQ; i++) hit[i] = (row[i] == open_row);

  always_comb
    for (int t = 0; t < NT; t++) begin
      cnt[t] = '0;
      for (int i = 0; i < NQ; i++)
        if (valid[i] && mark[i] && thr[i] == TW'(t)) cnt[t] = cnt[t] + CW'(1);
    end

  always_comb
    for (int i = 0; i < NQ; i++) begin
      int n;
      n = 0;
      for (int j = 0; j < NQ; j++)
        if (j != i && valid[j] && thr[j] == thr[i] &&
            (age[j] > age[i] || (age[j] == age[i] && j < i)))
          n++;
      mark_new[i] = valid[i] && (n < CAP);
    end

  always_comb begin
    slot = '0;
    for (int i = NQ - 1; i >= 0; i--)
      if (!valid[i]) slot = IW'(i);
  end

  always_comb begin
    win = '0;
    for (int i = 1; i < NQ; i++) begin
      logic take;
      if (!valid[win])                take = valid[i];
      else if (!valid[i])             take = 1'b0;
      else if (mark[i] != mark[win])  take = mark[i];
      else if (hit[i] != hit[win])    take = hit[i];
      else if (thr[i] != thr[win])
        take = (cnt[thr[i]] < cnt[thr[win]]) ||
               (cnt[thr[i]] == cnt[thr[win]] && thr[i] < thr[win]);
      else                            take = age[i] > age[win];
      if (take) win = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      valid       <= '0;
      mark        <= '0;
      open_row    <= '0;
      grant_valid <= 1'b0;
      grant_idx   <= '0;
      grant_row   <= '0;
      for (int i = 0; i < NQ; i++) begin
        thr[i] <= '0;
        row[i] <= '0;
        age[i] <= '0;
      end
    end else begin
      grant_valid <= fire;
      for (int i = 0; i < NQ; i++)
        if (valid[i] && age[i] != '1) age[i] <= age[i] + AW'(1);
      if (form) mark <= mark_new;
      if (fire) begin
        grant_idx  <= win;
        grant_row  <= row[win];
        open_row   <= row[win];
        valid[win] <= 1'b0;
        mark[win]  <= 1'b0;
      end
      if (req_valid && !full) begin
        valid[slot] <= 1'b1;
        mark[slot]  <= 1'b0;
        thr[slot]   <= req_thread;
        row[slot]   <= req_row;
        age[slot]   <= '0;
      end
    end

  // R7
  gnt_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $past(bank_ready));

  // R7
  gnt_frees_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !valid[grant_idx]);

  // R2
  batch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> mark[win]);

  generate
    for (genvar t = 0; t < NT; t++) begin : g_thr
      // R1
      tag_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[t] <= CW'(CAP));
    end
    for (genvar q = 0; q < NQ; q++) begin : g_ent
      // R6
      batch_when_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mark[q]) |-> !$past(have_batch));
    end
  endgenerate

endmodule

// File: tb/test_batch_sched.sv
module test_batch_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_thread = '0;
  logic [7:0] req_row = '0;
  logic       bank_ready = 1'b0;
  logic       grant_valid;
  logic [2:0] grant_idx;
  logic [7:0] grant_row;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  batch_sched i_batch_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_thread(req_thread),
    .req_row(req_row), .bank_ready(bank_ready), .grant_valid(grant_valid),
    .grant_idx(grant_idx), .grant_row(grant_row)
  );

  // {req_valid, thread, row, bank_ready, exp_gv, exp_idx, exp_row, tag}
  localparam logic [27:0] VEC [0:22] = '{
    // load: T0 r5, T0 r5, T0 r9, T1 r9, T2 r5 (R8 slots 0..4)
    {1'b1, 2'd0, 8'd5, 1'b0, 1'b0, 3'd0, 8'd0, 4'd8},
    {1'b1, 2'd0, 8'd5, 1'b0, 1'b0, 3'd0, 8'd0, 4'd8},
    {1'b1, 2'd0, 8'd9, 1'b0, 1'b0, 3'd0, 8'd0, 4'd8},
    {1'b1, 2'd1, 8'd9, 1'b0, 1'b0, 3'd0, 8'd0, 4'd8},
    {1'b1, 2'd2, 8'd5, 1'b0, 1'b0, 3'd0, 8'd0, 4'd8},
    // R6 batch opens, no grant
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 3'd0, 8'd0, 4'd6},
    // R4 T1 has fewest tagged
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 3'd3, 8'd9, 4'd4},
    // R1 slot 2 untagged, its hit on row 9 does not count
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 3'd4, 8'd5, 4'd1},
    // R5 older of two equal T0 hits
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 3'd0, 8'd5, 4'd5},
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 3'd1, 8'd5, 4'd5},
    // R6 second batch bubble, then leftover
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 3'd0, 8'd0, 4'd6},
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 3'd2, 8'd9, 4'd6},
    // R7 empty queue, pulse gone
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 3'd0, 8'd0, 4'd7},
    // load: T2 r9, T2 r8, T1 r4
    {1'b1, 2'd2, 8'd9, 1'b0, 1'b0, 3'd0, 8'd0, 4'd8},
    {1'b1, 2'd2, 8'd8, 1'b0, 1'b0, 3'd0, 8'd0, 4'd8},
    {1'b1, 2'd1, 8'd4, 1'b0, 1'b0, 3'd0, 8'd0, 4'd8},
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 3'd0, 8'd0, 4'd6},
    // R3 hit beats better rank; late T3 r9 arrives into slot 3
    {1'b1, 2'd3, 8'd9, 1'b1, 1'b1, 3'd0, 8'd9, 4'd3},
    // R2 tagged miss beats untagged hit; R4 equal counts, lower thread
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 3'd2, 8'd4, 4'd2},
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 3'd1, 8'd8, 4'd2},
    // R6 late arrival waits for next batch
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 3'd0, 8'd0, 4'd6},
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 3'd3, 8'd9, 4'd6},
    {1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 3'd0, 8'd0, 4'd7}
  };

  task automatic check(input bit ok, input int tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    // R9 reset state
    repeat (3) @(negedge clk);
    check(grant_valid == 1'b0, 9, "grant during reset", grant_valid, 0);
    rst_n = 1'b1;
    bank_ready = 1'b1;
    @(negedge clk);
    check(grant_valid == 1'b0, 9, "grant on empty queue after reset", grant_valid, 0);
    bank_ready = 1'b0;

    for (int k = 0; k < 23; k++) begin
      logic [27:0] v;
      v = VEC[k];
      req_valid  = v[27];
      req_thread = v[26:25];
      req_row    = v[24:17];
      bank_ready = v[16];
      @(negedge clk);
      check(grant_valid == v[15], int'(v[3:0]), "grant_valid", grant_valid, v[15]);
      if (v[15]) begin
        check(grant_idx == v[14:12], int'(v[3:0]), "grant_idx", grant_idx, v[14:12]);
        check(grant_row == v[11:4], int'(v[3:0]), "grant_row", grant_row, v[11:4]);
      end
    end

    // R8 fill all slots plus one extra; R5 and R1 oldest-first batches of two
    req_valid = 1'b0;
    bank_ready = 1'b0;
    for (int k = 0; k < 9; k++) begin
      req_valid  = 1'b1;
      req_thread = 2'd0;
      req_row    = 8'(16 + k);
      @(negedge clk);
    end
    req_valid = 1'b0;
    bank_ready = 1'b1;
    n = 0;
    for (int c = 0; c < 18; c++) begin
      @(negedge clk);
      if (grant_valid) begin
        check(grant_idx == 3'(n), 5, "drain order idx", grant_idx, n);
        check(grant_row == 8'(16 + n), 1, "drain order row", grant_row, 16 + n);
        n++;
      end
    end
    check(n == 8, 8, "grants after overfill", n, 8);
    bank_ready = 1'b0;

    // R9 reset clears the queue
    req_valid = 1'b1;
    req_row   = 8'd0;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bank_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(grant_valid == 1'b0, 9, "queue not empty after reset", grant_valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule